// File: doc/BRIEF.md
# Serial Three-Bit Combination Lock

This controller opens a lock when an operator keys in a secret code one bit at a time. The operator sets a two-position switch to the value of one key bit and then presses an enter button. After three such steps the controller gives a verdict: an unlock output if every entered bit equals the stored combination, or an error output if any of them differed. The stored combination lives in a register that is loaded in parallel from a set of input pins under a load strobe. It is not built into the state logic.

A mismatch is noted internally and kept hidden until the last bit has been entered, so an observer cannot learn how many leading bits were right. The verdict stays on until the operator presses the reset input. Any enter presses made before that reset are ignored. The key length is a parameter with a default of three.

Top module: `combo_lock_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller returns to waiting for the first key bit. After that edge `unlock` and `error` are both 0, and any recorded mismatch is cleared.
- R2: At each clock edge where `combo_ld` is 1, the combination register takes `combo_in`. At other edges it holds its value. `rst` does not change it.
- R3: Key bits are compared in the order they are entered. The first accepted bit is compared against `combo_in` bit 0 as loaded, the second against bit 1, and the third against bit 2.
- R4: A bit is accepted only at a clock edge where `enter_btn` is 1 and was 0 at the previous edge. `key_bit` is sampled at that edge. Holding `enter_btn` high, or changing `key_bit` while it is held, accepts no further bits. `enter_btn` counts as low at the first edge after reset.
- R5: While fewer than three bits have been accepted since reset, `unlock` and `error` both stay 0, even if a bit entered so far was wrong.
- R6: At the clock edge that accepts the third bit, `unlock` becomes 1 if all three bits matched. Otherwise `error` becomes 1.
- R7: `unlock` and `error` are never 1 together. Once either is set, it stays set, and further presses have no effect until `rst`.
- R8: A mismatch in one attempt does not carry over into the next attempt: after `rst`, a fully matching key gives `unlock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset that restarts entry |
| enter_btn | input | 1 | Enter button level; each rising edge accepts one bit |
| key_bit | input | 1 | Key switch position |
| combo_ld | input | 1 | Load strobe for the combination register |
| combo_in | input | 3 | Combination value to load; bit 0 is compared first |
| unlock | output | 1 | Key matched; held until reset |
| error | output | 1 | Key mismatched; held until reset |

## Verification
A bit is accepted at the first rising clock edge that sees `enter_btn` high. The verdict is registered at that same edge for the third bit, so both outputs are due one edge after the third press begins. The bench drives inputs on falling edges and samples on the falling edge after each press has been released, which is always at least one edge past acceptance. After the first and second presses it checks that both outputs are still 0. Extra presses after the verdict, and long holds with the switch toggling, are followed by a sample before the next stimulus so that any unwanted change would show at the outputs.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [1:0] {
        LK_COLLECT = 2'd0,
        LK_OPEN    = 2'd1,
        LK_ALARM   = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic open;
        logic alarm;
    } verdict_t;

    function automatic verdict_t verdict_of(lock_state_e s);
        verdict_t v;
        v.open  = (s == LK_OPEN);
        v.alarm = (s == LK_ALARM);
        return v;
    endfunction

    function automatic logic bit_differs(logic entered, logic expected);
        return entered ^ expected;
    endfunction

endpackage

// File: rtl/lock_press_detect.sv
module lock_press_detect (
    input  logic clk,
    input  logic rst,
    input  logic btn,
    output logic press
);
    logic btn_prev;

    always_ff @(posedge clk) begin
        if (rst) btn_prev <= 1'b0;
        else     btn_prev <= btn;
    end

    assign press = btn & ~btn_prev;
endmodule

// File: rtl/lock_combo_reg.sv
module lock_combo_reg #(
    parameter int KEY_LEN = 3
) (
    input  logic               clk,
    input  logic               load,
    input  logic [KEY_LEN-1:0] din,
    output logic [KEY_LEN-1:0] q
);
    for (genvar g = 0; g < KEY_LEN; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (load) q[g] <= din[g];
        end
    end
endmodule

// File: rtl/lock_entry_fsm.sv
module lock_entry_fsm
    import lock_pkg::*;
#(
    parameter int KEY_LEN = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               press,
    input  logic               key_bit,
    input  logic [KEY_LEN-1:0] combo,
    output verdict_t           verdict
);
    localparam int IW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

    lock_state_e state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic miss_q, miss_d;
    logic last_bit;

    assign last_bit = (idx_q == IW'(KEY_LEN - 1));

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        miss_d  = miss_q;
        if (state_q == LK_COLLECT && press) begin
            miss_d = miss_q | bit_differs(key_bit, combo[idx_q]);
            if (last_bit) begin
                state_d = miss_d ? LK_ALARM : LK_OPEN;
                idx_d   = '0;
            end else begin
                idx_d = idx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_COLLECT;
            idx_q   <= '0;
            miss_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            miss_q  <= miss_d;
        end
    end

    assign verdict = verdict_of(state_q);
endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
    import lock_pkg::*;
#(
    parameter int KEY_LEN = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enter_btn,
    input  logic               key_bit,
    input  logic               combo_ld,
    input  logic [KEY_LEN-1:0] combo_in,
    output logic               unlock,
    output logic               error
);
    logic               press;
    logic [KEY_LEN-1:0] combo_q;
    verdict_t           verdict;

    lock_press_detect u_press (
        .clk   (clk),
        .rst   (rst),
        .btn   (enter_btn),
        .press (press)
    );

    lock_combo_reg #(.KEY_LEN(KEY_LEN)) u_combo (
        .clk  (clk),
        .load (combo_ld),
        .din  (combo_in),
        .q    (combo_q)
    );

    lock_entry_fsm #(.KEY_LEN(KEY_LEN)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .press   (press),
        .key_bit (key_bit),
        .combo   (combo_q),
        .verdict (verdict)
    );

    assign unlock = verdict.open;
    assign error  = verdict.alarm;
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk #(
    parameter int KEY_LEN = 3
) (
    input logic clk,
    input logic rst,
    input logic enter_btn,
    input logic unlock,
    input logic error
);
    localparam int CW = $clog2(KEY_LEN + 1);

    logic          btn_seen;
    logic [CW-1:0] presses;

    // Independent count of accepted presses, saturating at KEY_LEN.
    always_ff @(posedge clk) begin
        if (rst) begin
            btn_seen <= 1'b0;
            presses  <= '0;
        end else begin
            btn_seen <= enter_btn;
            if (enter_btn && !btn_seen && presses != CW'(KEY_LEN))
                presses <= presses + 1'b1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (!unlock && !error));

    assert_hidden_until_done_R5: assert property (@(posedge clk) disable iff (rst)
        (presses < CW'(KEY_LEN)) |-> (!unlock && !error));

    assert_verdict_due_R6: assert property (@(posedge clk) disable iff (rst)
        (presses == CW'(KEY_LEN)) |-> (unlock || error));

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(unlock && error));

    assert_unlock_held_R7: assert property (@(posedge clk) disable iff (rst)
        unlock |=> unlock);

    assert_error_held_R7: assert property (@(posedge clk) disable iff (rst)
        error |=> error);
endmodule

bind combo_lock_ctrl combo_lock_chk #(.KEY_LEN(KEY_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enter_btn (enter_btn),
    .unlock    (unlock),
    .error     (error)
);

// File: tb/sim_combo_lock_ctrl.sv
`timescale 1ns/1ps
module sim_combo_lock_ctrl;
    localparam int KL = 3;

    logic clk = 1'b0;
    logic rst, enter_btn, key_bit, combo_ld;
    logic [KL-1:0] combo_in;
    logic unlock, error;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    combo_lock_ctrl #(.KEY_LEN(KL)) u0 (
        .clk(clk), .rst(rst), .enter_btn(enter_btn), .key_bit(key_bit),
        .combo_ld(combo_ld), .combo_in(combo_in), .unlock(unlock), .error(error)
    );

    // Expected {unlock,error}: key[i] is the i-th bit entered, compared to combo[i].
    function automatic logic [1:0] exp_verdict(logic [KL-1:0] key, logic [KL-1:0] combo);
        return (key == combo) ? 2'b10 : 2'b01;
    endfunction

    task automatic check(string req, logic [1:0] exp);
        checks++;
        if ({unlock, error} !== exp) begin
            failures++;
            $display("FAIL %s: {unlock,error} act=%b exp=%b", req, {unlock, error}, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; enter_btn = 1'b0;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic load(logic [KL-1:0] c);
        @(negedge clk); combo_in = c; combo_ld = 1'b1;
        @(negedge clk); combo_ld = 1'b0; combo_in = ~c;
    endtask

    // Press with the switch at b, hold for `hold` cycles (switch toggling), then release.
    task automatic press(logic b, int hold, int gap);
        @(negedge clk); key_bit = b; enter_btn = 1'b1;
        for (int i = 1; i < hold; i++) begin
            @(negedge clk); key_bit = ~key_bit;
        end
        @(negedge clk); enter_btn = 1'b0; key_bit = $urandom_range(0, 1);
        for (int i = 0; i < gap; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog: act=timeout exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [KL-1:0] c, k;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; enter_btn = 1'b0; key_bit = 1'b0; combo_ld = 1'b0; combo_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", 2'b00);

        // Directed: order of comparison, combination 3'b001 (bit0 first).
        load(3'b001);
        do_reset();
        press(1'b1, 1, 1); check("R5 after bit 1", 2'b00);
        press(1'b0, 1, 1); check("R5 after bit 2", 2'b00);
        press(1'b0, 1, 1); check("R3 ordered match unlocks", 2'b10);
        do_reset();
        check("R1 reset clears unlock", 2'b00);
        press(1'b0, 1, 0); press(1'b0, 1, 0); press(1'b1, 1, 1);
        check("R3 reversed order errors", 2'b01);

        // Early mismatch stays hidden, then R8 clean retry.
        do_reset();
        press(1'b0, 1, 1); check("R5 mismatch hidden bit 1", 2'b00);
        press(1'b1, 2, 1); check("R5 mismatch hidden bit 2", 2'b00);
        press(1'b0, 1, 1); check("R6 mismatch verdict", 2'b01);
        press(1'b1, 1, 1); check("R7 press after error ignored", 2'b01);
        do_reset();
        press(1'b1, 1, 0); press(1'b0, 1, 0); press(1'b0, 1, 1);
        check("R8 mismatch cleared by reset", 2'b10);

        // R4: long holds with toggling switch count as one bit each.
        do_reset();
        press(1'b1, 6, 1); check("R4 long hold one bit", 2'b00);
        press(1'b0, 5, 1); check("R4 second long hold", 2'b00);
        press(1'b0, 4, 1); check("R4 third bit accepted", 2'b10);

        // R2: reset keeps combination; combo_in without strobe is ignored.
        load(3'b110);
        do_reset();
        combo_in = 3'b001;
        press(1'b0, 1, 0); press(1'b1, 1, 0); press(1'b1, 1, 1);
        check("R2 loaded value held across reset", 2'b10);

        // Random trials.
        for (int t = 0; t < 60; t++) begin
            c = KL'($urandom);
            k = ($urandom_range(0, 1) == 1) ? c : KL'($urandom);
            load(c);
            do_reset();
            for (int i = 0; i < KL; i++) begin
                press(k[i], $urandom_range(1, 4), $urandom_range(0, 2));
                if (i < KL - 1) check("R5 random partial", 2'b00);
                else            check("R6 random verdict", exp_verdict(k, c));
            end
            press(~k[0], $urandom_range(1, 3), 1);
            check("R7 random extra press", exp_verdict(k, c));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule